// File: doc/BRIEF.md
# Dual-Modulus 8/9 Prescaler

This block divides a fast input clock by either eight or nine, as selected by a single modulus-select input. A core stage built from two D flip-flops with NOR-style feedback divides by two or by three. Two toggle stages follow it, so each output period spans four core cycles. The core stretches to three input clocks only in the last core cycle of an output period, and only when nine is selected. The divided clock is therefore eight or nine input clocks long.

The block also emits a one-clock pulse at the start of every output period, which an external swallow counter uses to decide the modulus for the next period. The modulus-select input is captured once, on the input-clock edge that opens an output period, and holds for the whole period. A change at any other time cannot shorten or glitch a period. The model is a synchronous register-level equivalent of the divider chain and is clocked by the fast clock.

Top module: `dm89_prescaler`

## Requirements
- R1: While the active-low reset is low, `clk_out` and `period_tick` are both 0.
- R2: An output period that opens with `mod_sel` = 1 lasts exactly 8 input clocks, measured from one `period_tick` to the next.
- R3: An output period that opens with `mod_sel` = 0 lasts exactly 9 input clocks.
- R4: `mod_sel` is sampled only on the rising input-clock edge that opens a period (the edge after which `period_tick` is 1). Its value at any other edge has no effect on that period's length.
- R5: `period_tick` is 1 for exactly one input clock per period, in the first clock during which `clk_out` is 1. It is never 1 at any other time.
- R6: `clk_out` stays high for exactly 4 input clocks in every period. It is low for the remaining 4 (divide by 8) or 5 (divide by 9).
- R7: The first output period opens on the first rising input-clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_sel | input | 1 | Modulus select: 1 gives divide by 8, 0 gives divide by 9 |
| clk_out | output | 1 | Divided clock, rises at the start of each period |
| period_tick | output | 1 | One-clock pulse at the start of each period |

## Verification
The bench goes after the moment at which the modulus is taken. It changes `mod_sel` on every input clock, on every period boundary, and for all of a period except its opening edge. A design that sampled continuously would give periods of the wrong length or a glitched period. Another case is a select that toggles on each period, where a design that lagged the select by one period would swap the 8 and 9 lengths. The bench also applies reset in mid-period and checks the first period after release, because a design that left the stage registers in the wrong phase would start late or with a short high phase. Finally, it measures the high time and the pulse width in every period, so a stretch cycle placed anywhere other than the low half would show up as a wrong duty cycle.

// File: rtl/dm89_prescaler.sv
module dm89_prescaler (
  input  logic clk_in,
  input  logic rst_n,
  input  logic mod_sel,
  output logic clk_out,
  output logic period_tick
);

  logic q1, q2;
  logic t1, t2;
  logic sel_q;
  logic tick_q;

  wire stretch  = ~sel_q & t1 & t2;
  wire core_end = ~q1 & ~(q2 & stretch);
  wire per_end  = core_end & t1 & t2;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= ~(q1 | (q2 & stretch));
      q2 <= q1;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      t1 <= 1'b1;
      t2 <= 1'b1;
    end else if (core_end) begin
      t1 <= ~t1;
      if (t1) t2 <= ~t2;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= per_end;
      if (per_end) sel_q <= mod_sel;
    end
  end

  assign clk_out     = ~t2;
  assign period_tick = tick_q;

  AST_TICK_ON_RISE: assert property (@(posedge clk_in) disable iff (!rst_n)
    period_tick |-> (clk_out && !$past(clk_out)));                          // R5
  AST_TICK_SINGLE: assert property (@(posedge clk_in) disable iff (!rst_n)
    period_tick |=> !period_tick);                                          // R5
  AST_RISE_HAS_TICK: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(clk_out) |-> period_tick);                                        // R5
  AST_SEL_HELD: assert property (@(posedge clk_in) disable iff (!rst_n)
    !period_tick |-> $stable(sel_q));                                       // R4
  AST_CORE_LEGAL: assert property (@(posedge clk_in) disable iff (!rst_n)
    !(q1 && q2));                                                           // R6

endmodule

// File: tb/sim_dm89_prescaler.sv
module sim_dm89_prescaler;
  logic clk_in = 1'b0;
  logic rst_n = 1'b0;
  logic mod_sel = 1'b0;
  logic clk_out, period_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dm89_prescaler u0 (.clk_in(clk_in), .rst_n(rst_n), .mod_sel(mod_sel),
                     .clk_out(clk_out), .period_tick(period_tick));

  always #4 clk_in = ~clk_in;

  function automatic int exp_len(input logic m);
    return m ? 8 : 9;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  int cnt, hi_run, since_rel, periods, phase;
  logic m_start, prev_out, prev_tick;
  bit started;

  task automatic reset_chip();
    @(negedge clk_in);
    rst_n = 1'b0;
    #1;
    chk(clk_out == 1'b0 && period_tick == 1'b0, "R1 reset outputs",
        {clk_out, period_tick}, 0);
    repeat (3) @(negedge clk_in);
    chk(clk_out == 1'b0 && period_tick == 1'b0, "R1 held reset",
        {clk_out, period_tick}, 0);
    rst_n = 1'b1;
    started = 1'b0; since_rel = 0; prev_out = 1'b0; prev_tick = 1'b0;
    cnt = 0; hi_run = 0;
  endtask

  task automatic step();
    @(negedge clk_in);
    since_rel++;
    if (!started) begin
      if (period_tick) chk(since_rel == 1, "R7 first period start", since_rel, 1);
    end
    if (clk_out && !prev_out)
      chk(period_tick == 1'b1, "R5 tick on rise", period_tick, 1);
    if (period_tick) begin
      chk(!prev_tick, "R5 tick width", prev_tick, 0);
      if (started)
        chk(cnt == exp_len(m_start), m_start ? "R2/R4 period" : "R3/R4 period",
            cnt, exp_len(m_start));
      started = 1'b1;
      m_start = mod_sel;
      cnt = 1;
      periods++;
    end else begin
      cnt++;
      if (period_tick == 1'b0 && clk_out && prev_out == 1'b0)
        chk(0, "R5 missing tick", 0, 1);
    end
    if (clk_out) hi_run++;
    if (!clk_out && prev_out) begin
      chk(hi_run == 4, "R6 high time", hi_run, 4);
      hi_run = 0;
    end
    prev_out = clk_out;
    prev_tick = period_tick;
  endtask

  initial begin
    void'($urandom(32'h5EED_0089));
    periods = 0; started = 1'b0;
    reset_chip();
    mod_sel = 1'b1;
    repeat (12) begin step(); end
    mod_sel = 1'b1;
    for (int i = 0; i < 100; i++) step();
    mod_sel = 1'b0;
    for (int i = 0; i < 100; i++) step();
    // toggle select on every period boundary
    for (int i = 0; i < 300; i++) begin
      step();
      if (period_tick) mod_sel = ~mod_sel;
    end
    // R4: hold 1 only at opening edge, 0 elsewhere (expect 8)
    for (int i = 0; i < 200; i++) begin
      step();
      mod_sel = (cnt == 8 && m_start == 1'b1) || (cnt == 9) ? 1'b1 : 1'b0;
      if (cnt == 7 && m_start == 1'b1) mod_sel = 1'b0;
    end
    // R4: 0 only at opening edge, 1 elsewhere
    for (int i = 0; i < 200; i++) begin
      step();
      mod_sel = (cnt == exp_len(m_start)) ? 1'b0 : 1'b1;
    end
    // random select every clock
    for (int i = 0; i < 3000; i++) begin
      step();
      mod_sel = $urandom_range(0, 1);
    end
    // mid-period reset then R7 again
    for (int i = 0; i < 3; i++) step();
    reset_chip();
    mod_sel = 1'b0;
    for (int i = 0; i < 60; i++) step();
    mod_sel = 1'b1;
    for (int i = 0; i < 60; i++) step();
    chk(periods > 400, "R2/R3 period count", periods, 401);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule